// File: doc/BRIEF.md
# Permission-Aware Set-Associative Tag Directory

This block holds the tag and state half of a set-associative cache. It keeps no data. For every way of every set it stores a line tag, a 2-bit access permission and a true-LRU age. A cache controller drives one command at a time into it. Each command can check an access, test for presence, ask whether the set has room, allocate or free a line, rewrite a line's permission, ask which line would be evicted, or mark a line most recently used.

A hit is more than a tag match. The stored permission must also allow the kind of request. A way whose permission is the not-present code counts as a free slot. Every command is taken in one cycle. The response appears on registered outputs on the following cycle, with an error flag for a command whose precondition does not hold. The directory is meant to sit beside a data array that the controller indexes with the returned way.

Top module: `perm_tag_dir`

## Requirements
- R1: After reset every way of every set is empty (permission 00), `rspValid` is low, an availability query returns 1 and a presence test misses in every set.
- R2: The set is picked by the `SET_W = log2(TOTAL_LINES/WAYS)` address bits just above the `OFFSET_W` block-offset bits. The tag is the bits above those. Offset bits take no part in matching, and sets never affect each other.
- R3: A way matches only if its stored tag equals the request tag and its permission is not 00. A presence test (op 1) reports the lowest matching way with `rspHit`=1, or `rspHit`=0 with way 0 and permission 0.
- R4: Permission codes are 00 not-present, 01 invalid, 10 read-only and 11 read-write. Request types are 0 load, 1 instruction fetch and 2 store. An access check (op 0) hits when the matched line is 11, or when it is 10 and the request is a load or a fetch. Every other case misses.
- R5: The availability query (op 2) returns `rspAvail`=1 when some way of the set holds the request tag, whatever its permission, or when some way has permission 00. `rspAvail` reports this pre-command value for every command.
- R6: Allocate (op 3) writes the tag into the lowest-numbered way with permission 00, sets that way to 01 and makes it most recently used. The response carries that way and permission 01.
- R7: Deallocate (op 4) returns the matched way to permission 00 and reports permission 00.
- R8: Permission change (op 5) writes `newPerm` into the matched line. If no line matches, nothing changes.
- R9: Victim probe (op 6) on a set with no available way returns the way whose age is oldest. It also returns that line's address: stored tag, set index, and offset bits zero.
- R10: Age order is true LRU. A touch makes a way youngest and ages only the ways younger than it. An access check that matches touches the way even when the permission check fails. Touch (op 7) does the same for a matching line. Presence, availability and probe leave age order unchanged.
- R11: `rspErr` is 1 in four cases: an allocate whose tag is already present, an allocate into a set with no free way, a deallocate with no matching line, and a probe of a set that still has room. A command that errors changes no state.
- R12: Each command accepted with `cmdValid` produces `rspValid`=1 with its results on the next cycle. With no command, `rspValid` is 0 the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdOp | input | 3 | Command code, 0..7 as in R3-R10 |
| reqType | input | 2 | Request kind for access checks (R4) |
| reqAddr | input | ADDR_W | Request address |
| newPerm | input | 2 | Permission written by op 5 |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | Access hit (op 0) or tag match (other ops) |
| rspWay | output | WAY_W | Way the command acted on, else 0 |
| rspPerm | output | 2 | Permission of that way after the command, else 0 |
| rspAvail | output | 1 | Set availability before the command |
| rspVictim | output | ADDR_W | Victim line address for a legal probe, else 0 |
| rspErr | output | 1 | Precondition violation |

## Verification
Some properties can be checked on every cycle from the ports alone. The assertions cover these: the one-cycle response timing, the constraint on access hits (a store hit needs read-write, any hit needs a readable permission), the tie between a probe's error and the availability flag, and the permission an allocate or deallocate reports.

Other behaviour depends on state built up over a sequence of commands. This includes the lowest-free-way choice, LRU ordering after mixed touches, failed-permission accesses that still age the set, silent permission changes on missing tags, and set independence. Only the bench's scripted sweeps over every set and every permission and request-type pair can show these. The bench compares each response against its own model of the directory.

// File: rtl/ptd_pkg.sv
package ptd_pkg;

  typedef enum logic [2:0] {
    OP_ACCESS  = 3'd0,
    OP_PRESENT = 3'd1,
    OP_AVAIL   = 3'd2,
    OP_ALLOC   = 3'd3,
    OP_DEALLOC = 3'd4,
    OP_SETPERM = 3'd5,
    OP_PROBE   = 3'd6,
    OP_TOUCH   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    RQ_LOAD  = 2'd0,
    RQ_FETCH = 2'd1,
    RQ_STORE = 2'd2,
    RQ_RSVD  = 2'd3
  } req_e;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_INV  = 2'b01;
  localparam logic [1:0] PERM_RO   = 2'b10;
  localparam logic [1:0] PERM_RW   = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic fire;
    logic allocWr;
    logic clearWr;
    logic permWr;
    logic touchMatch;
    logic touchAlloc;
    logic selMatch;
    logic selFree;
    logic selVictim;
    logic hit;
    logic err;
  } strobe_t;

endpackage

// File: rtl/ptd_ctrl.sv
module ptd_ctrl
  import ptd_pkg::*;
(
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [1:0] reqType,
  input  logic       anyMatch,
  input  logic       anyFree,
  input  logic       availFlag,
  input  logic [1:0] matchPerm,
  output strobe_t    strobe
);

  op_e  op;
  req_e rq;
  logic permOk;

  assign op = op_e'(cmdOp);
  assign rq = req_e'(reqType);

  always_comb begin
    permOk = (matchPerm == PERM_RW) ||
             ((matchPerm == PERM_RO) && ((rq == RQ_LOAD) || (rq == RQ_FETCH)));
  end

  always_comb begin
    strobe      = '0;
    strobe.fire = cmdValid;
    if (cmdValid) begin
      strobe.hit = anyMatch;
      unique case (op)
        OP_ACCESS: begin
          strobe.hit        = anyMatch && permOk;
          strobe.touchMatch = anyMatch;
          strobe.selMatch   = anyMatch;
        end
        OP_PRESENT: begin
          strobe.selMatch = anyMatch;
        end
        OP_AVAIL: begin
        end
        OP_ALLOC: begin
          if (anyMatch || !anyFree) begin
            strobe.err = 1'b1;
          end else begin
            strobe.allocWr    = 1'b1;
            strobe.touchAlloc = 1'b1;
            strobe.selFree    = 1'b1;
          end
        end
        OP_DEALLOC: begin
          if (!anyMatch) begin
            strobe.err = 1'b1;
          end else begin
            strobe.clearWr  = 1'b1;
            strobe.selMatch = 1'b1;
          end
        end
        OP_SETPERM: begin
          strobe.permWr   = anyMatch;
          strobe.selMatch = anyMatch;
        end
        OP_PROBE: begin
          strobe.err       = availFlag;
          strobe.selVictim = !availFlag;
        end
        OP_TOUCH: begin
          strobe.touchMatch = anyMatch;
          strobe.selMatch   = anyMatch;
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/ptd_datapath.sv
module ptd_datapath
  import ptd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int OFFSET_W = 4,
  parameter int SETS     = 4,
  parameter int WAYS     = 4,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int TAG_W   = ADDR_W - OFFSET_W - SET_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        newPerm,
  input  strobe_t           strobe,
  output logic              anyMatch,
  output logic              anyFree,
  output logic              availFlag,
  output logic [1:0]        matchPerm,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WAY_W-1:0]  rspWay,
  output logic [1:0]        rspPerm,
  output logic              rspAvail,
  output logic [ADDR_W-1:0] rspVictim,
  output logic              rspErr
);

  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  logic [TAG_W-1:0] tagArr  [SETS][WAYS];
  logic [1:0]       permArr [SETS][WAYS];
  logic [WAY_W-1:0] ageArr  [SETS][WAYS];

  logic [SET_W-1:0] setIdx;
  logic [TAG_W-1:0] reqTag;
  logic [WAYS-1:0]  tagEq, matchVec, freeVec, oldVec;
  logic [WAY_W-1:0] matchWay, freeWay, victimWay, touchWay, selWay;
  logic             doTouch, selAny;
  logic [1:0]       postPerm;
  logic [ADDR_W-1:0] victimAddr;

  assign setIdx = reqAddr[OFFSET_W +: SET_W];
  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];

  // per-way compare lanes
  for (genvar w = 0; w < WAYS; w++) begin : g_lane
    assign tagEq[w]    = (tagArr[setIdx][w] == reqTag);
    assign freeVec[w]  = (permArr[setIdx][w] == PERM_NONE);
    assign matchVec[w] = tagEq[w] && !freeVec[w];
    assign oldVec[w]   = (ageArr[setIdx][w] == OLDEST);
  end

  // lowest-index priority encoders
  always_comb begin
    matchWay  = '0;
    freeWay   = '0;
    victimWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (matchVec[w]) matchWay  = WAY_W'(w);
      if (freeVec[w])  freeWay   = WAY_W'(w);
      if (oldVec[w])   victimWay = WAY_W'(w);
    end
  end

  assign anyMatch  = |matchVec;
  assign anyFree   = |freeVec;
  assign availFlag = (|tagEq) || anyFree;
  assign matchPerm = anyMatch ? permArr[setIdx][matchWay] : PERM_NONE;

  assign doTouch  = strobe.touchMatch || strobe.touchAlloc;
  assign touchWay = strobe.touchAlloc ? freeWay : matchWay;

  assign selAny = strobe.selMatch || strobe.selFree || strobe.selVictim;
  always_comb begin
    selWay = '0;
    if (strobe.selFree)        selWay = freeWay;
    else if (strobe.selVictim) selWay = victimWay;
    else if (strobe.selMatch)  selWay = matchWay;
  end

  always_comb begin
    if (!selAny)               postPerm = PERM_NONE;
    else if (strobe.allocWr)   postPerm = PERM_INV;
    else if (strobe.clearWr)   postPerm = PERM_NONE;
    else if (strobe.permWr)    postPerm = newPerm;
    else                       postPerm = permArr[setIdx][selWay];
  end

  assign victimAddr = {tagArr[setIdx][victimWay], setIdx, {OFFSET_W{1'b0}}};

  // state arrays
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tagArr[s][w]  <= '0;
          permArr[s][w] <= PERM_NONE;
          ageArr[s][w]  <= WAY_W'(w);
        end
      end
    end else begin
      if (strobe.allocWr) begin
        tagArr[setIdx][freeWay]  <= reqTag;
        permArr[setIdx][freeWay] <= PERM_INV;
      end
      if (strobe.clearWr) begin
        tagArr[setIdx][matchWay]  <= '0;
        permArr[setIdx][matchWay] <= PERM_NONE;
      end
      if (strobe.permWr) begin
        permArr[setIdx][matchWay] <= newPerm;
      end
      if (doTouch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touchWay)
            ageArr[setIdx][w] <= '0;
          else if (ageArr[setIdx][w] < ageArr[setIdx][touchWay])
            ageArr[setIdx][w] <= ageArr[setIdx][w] + 1'b1;
        end
      end
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspWay    <= '0;
      rspPerm   <= PERM_NONE;
      rspAvail  <= 1'b0;
      rspVictim <= '0;
      rspErr    <= 1'b0;
    end else begin
      rspValid <= strobe.fire;
      if (strobe.fire) begin
        rspHit    <= strobe.hit;
        rspWay    <= selAny ? selWay : '0;
        rspPerm   <= postPerm;
        rspAvail  <= availFlag;
        rspVictim <= strobe.selVictim ? victimAddr : '0;
        rspErr    <= strobe.err;
      end
    end
  end

endmodule

// File: rtl/perm_tag_dir.sv
module perm_tag_dir
  import ptd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int OFFSET_W    = 4,
  parameter int TOTAL_LINES = 16,
  parameter int WAYS        = 4,
  localparam int SETS       = TOTAL_LINES / WAYS,
  localparam int WAY_W      = $clog2(WAYS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [1:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        newPerm,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WAY_W-1:0]  rspWay,
  output logic [1:0]        rspPerm,
  output logic              rspAvail,
  output logic [ADDR_W-1:0] rspVictim,
  output logic              rspErr
);

  strobe_t    strobe;
  logic       anyMatch, anyFree, availFlag;
  logic [1:0] matchPerm;

  ptd_ctrl u_ctrl (
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .reqType   (reqType),
    .anyMatch  (anyMatch),
    .anyFree   (anyFree),
    .availFlag (availFlag),
    .matchPerm (matchPerm),
    .strobe    (strobe)
  );

  ptd_datapath #(
    .ADDR_W   (ADDR_W),
    .OFFSET_W (OFFSET_W),
    .SETS     (SETS),
    .WAYS     (WAYS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqAddr   (reqAddr),
    .newPerm   (newPerm),
    .strobe    (strobe),
    .anyMatch  (anyMatch),
    .anyFree   (anyFree),
    .availFlag (availFlag),
    .matchPerm (matchPerm),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspWay    (rspWay),
    .rspPerm   (rspPerm),
    .rspAvail  (rspAvail),
    .rspVictim (rspVictim),
    .rspErr    (rspErr)
  );

endmodule

// File: rtl/perm_tag_dir_chk.sv
module perm_tag_dir_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [2:0] cmdOp,
  input logic [1:0] reqType,
  input logic       rspValid,
  input logic       rspHit,
  input logic [1:0] rspPerm,
  input logic       rspAvail,
  input logic       rspErr
);

  assert_rsp_on_cmd_R12: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> rspValid);

  assert_idle_no_rsp_R12: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !rspValid);

  assert_hit_readable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd0) |=> (!rspHit || rspPerm[1]));

  assert_store_needs_rw_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd0 && reqType == 2'd2) |=> (!rspHit || rspPerm == 2'b11));

  assert_alloc_invalid_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd3) |=> (rspErr || rspPerm == 2'b01));

  assert_dealloc_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd4) |=> (rspErr || rspPerm == 2'b00));

  assert_probe_err_avail_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd6) |=> (rspErr == rspAvail));

endmodule

bind perm_tag_dir perm_tag_dir_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .reqType  (reqType),
  .rspValid (rspValid),
  .rspHit   (rspHit),
  .rspPerm  (rspPerm),
  .rspAvail (rspAvail),
  .rspErr   (rspErr)
);

// File: tb/sim_perm_tag_dir.sv
module sim_perm_tag_dir;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int OFF_W  = 4;
  localparam int NSET   = 4;
  localparam int NWAY   = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [1:0]  reqType = '0;
  logic [15:0] reqAddr = '0;
  logic [1:0]  newPerm = '0;
  logic        rspValid, rspHit, rspAvail, rspErr;
  logic [1:0]  rspWay, rspPerm;
  logic [15:0] rspVictim;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mTag  [NSET][NWAY];
  int mPerm [NSET][NWAY];
  int mAge  [NSET][NWAY];

  always #(CLK_PERIOD/2) clk = ~clk;

  perm_tag_dir u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .reqType(reqType), .reqAddr(reqAddr), .newPerm(newPerm),
    .rspValid(rspValid), .rspHit(rspHit), .rspWay(rspWay),
    .rspPerm(rspPerm), .rspAvail(rspAvail), .rspVictim(rspVictim),
    .rspErr(rspErr)
  );

  function automatic string reqOf(int op);
    case (op)
      0: return "R4";  1: return "R3";  2: return "R5";  3: return "R6";
      4: return "R7";  5: return "R8";  6: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic touchWay(int s, int w);
    int a = mAge[s][w];
    for (int j = 0; j < NWAY; j++) begin
      if (j == w) mAge[s][j] = 0;
      else if (mAge[s][j] < a) mAge[s][j] = mAge[s][j] + 1;
    end
  endtask

  task automatic cmp(string req, string fld, int got, int exp);
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, fld, got, exp);
    end
  endtask

  // one command, expected values from the model, called at a negedge
  task automatic doCmd(int op, int rt, int tag, int s, int off, int np);
    int mm = -1, ff = -1, vic = 0, sel = -1;
    bit te = 0, av, ok, eHit, eErr;
    int ePerm, eVic;
    string rq = reqOf(op);
    for (int w = NWAY - 1; w >= 0; w--) begin
      if (mTag[s][w] == tag && mPerm[s][w] != 0) mm = w;
      if (mPerm[s][w] == 0) ff = w;
      if (mAge[s][w] == NWAY - 1) vic = w;
    end
    for (int w = 0; w < NWAY; w++) if (mTag[s][w] == tag) te = 1;
    av = te || (ff >= 0);
    eHit = (mm >= 0);
    if (op == 0 && mm >= 0)
      eHit = (mPerm[s][mm] == 3) || (mPerm[s][mm] == 2 && rt != 2);
    eErr = 0;
    eVic = 0;
    case (op)
      0, 1, 7: begin
        sel = mm;
        if (op != 1 && mm >= 0) touchWay(s, mm);
      end
      3: begin
        ok = (mm < 0) && (ff >= 0);
        eErr = !ok;
        if (ok) begin
          mTag[s][ff] = tag; mPerm[s][ff] = 1; touchWay(s, ff); sel = ff;
        end
      end
      4: begin
        eErr = (mm < 0);
        if (mm >= 0) begin mTag[s][mm] = 0; mPerm[s][mm] = 0; sel = mm; end
      end
      5: if (mm >= 0) begin mPerm[s][mm] = np; sel = mm; end
      6: begin
        eErr = av;
        if (!av) begin sel = vic; eVic = (mTag[s][vic] << (OFF_W + 2)) | (s << OFF_W); end
      end
      default: ;
    endcase
    ePerm = (sel >= 0) ? mPerm[s][sel] : 0;

    cmdOp    = 3'(op);
    reqType  = 2'(rt);
    reqAddr  = 16'((tag << (OFF_W + 2)) | (s << OFF_W) | off);
    newPerm  = 2'(np);
    cmdValid = 1'b1;
    @(negedge clk);
    checks++;
    cmp("R12", "rspValid", int'(rspValid), 1);
    cmp(rq, "hit", int'(rspHit), int'(eHit));
    cmp(rq, "way", int'(rspWay), (sel >= 0) ? sel : 0);
    cmp(rq, "perm", int'(rspPerm), ePerm);
    cmp("R5", "avail", int'(rspAvail), int'(av));
    cmp("R9", "victim", int'(rspVictim), eVic);
    cmp("R11", "err", int'(rspErr), int'(eErr));
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NSET; s++)
      for (int w = 0; w < NWAY; w++) begin
        mTag[s][w] = 0; mPerm[s][w] = 0; mAge[s][w] = w;
      end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset, no response
    checks++;
    cmp("R1", "rspValid", int'(rspValid), 0);

    // R1: every set empty
    for (int s = 0; s < NSET; s++) begin
      doCmd(2, 0, 7, s, 0, 0);
      doCmd(1, 0, 7, s, 0, 0);
    end

    for (int s = 0; s < NSET; s++) begin
      int b = s * 16 + 1;
      // R6: fill in way order
      for (int i = 0; i < NWAY; i++) doCmd(3, 0, b + i, s, 0, 0);
      // R11: full set and duplicate tag
      doCmd(3, 0, b + 9, s, 0, 0);
      doCmd(3, 0, b, s, 0, 0);
      // R5: full set, with and without tag match
      doCmd(2, 0, b + 9, s, 0, 0);
      doCmd(2, 0, b + 2, s, 0, 0);
      // R9: oldest is first allocated
      doCmd(6, 0, b + 9, s, 0, 0);
      // R4 R2: permission x request sweep with offset bits set
      for (int p = 3; p >= 1; p--) begin
        doCmd(5, 0, b + 1, s, 0, p);
        for (int rt = 0; rt < 3; rt++) doCmd(0, rt, b + 1, s, (s + 3) % 16, 0);
      end
      // R3: permission 00 hides the tag; R8: later change on missing tag ignored
      doCmd(5, 0, b + 1, s, 0, 0);
      doCmd(1, 0, b + 1, s, 0, 0);
      doCmd(5, 0, b + 1, s, 0, 3);
      doCmd(0, 2, b + 1, s, 0, 0);
      // R11: probe with room
      doCmd(6, 0, b + 9, s, 0, 0);
      // R6: reuse lowest free way
      doCmd(3, 0, b + 5, s, 0, 0);
      // R10: failing access still touches; then probe
      doCmd(0, 2, b + 5, s, 0, 0);
      doCmd(6, 0, b + 9, s, 0, 0);
      doCmd(7, 0, b, s, 0, 0);
      doCmd(1, 0, b + 3, s, 0, 0);
      doCmd(6, 0, b + 9, s, 0, 0);
      doCmd(7, 0, b + 12, s, 0, 0);
      doCmd(6, 0, b + 9, s, 0, 0);
      // R7: deallocate, then repeat is an error
      doCmd(4, 0, b + 2, s, 0, 0);
      doCmd(4, 0, b + 2, s, 0, 0);
      doCmd(1, 0, b + 2, s, 0, 0);
      doCmd(2, 0, b + 9, s, 0, 0);
    end

    // R2: earlier sets untouched by later traffic
    for (int s = 0; s < NSET; s++) doCmd(1, 0, s * 16 + 1, s, 5, 0);

    // R12: idle cycle gives no response
    @(negedge clk);
    checks++;
    cmp("R12", "idle rspValid", int'(rspValid), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule